// File: doc/BRIEF.md
# ROM CRC Signature Checker

This block runs a self-test of a read-only memory. After a start pulse it reads every byte of the ROM through a synchronous read port, in address order, one address per cycle. It folds each data byte into a 16-bit CRC register. The two highest addresses hold a reference CRC that was computed offline. The block does not fold those two bytes into the CRC. It captures them and compares them with the value it computed. Reading the ROM is the whole test, and the block never writes to the memory.

The fault model is unidirectional stuck-at. A word line or bit line can hold some bits at 0 only, or at 1 only. The CRC catches any single-bit error, any double-bit error, any odd number of flipped bits and any burst of adjacent errors up to 16 bits long. When the check ends, `done` rises and `pass` reports whether the two CRCs matched. `crc_out` shows the running CRC so that a failing part can be debugged. A new start clears the previous result and runs the whole sequence again.

Top module: `rom_crc_checker`

## Requirements
- R1: While reset is held and after it is released, `done`=0, `pass`=0, `rom_en`=0 and `crc_out`=0xFFFF.
- R2: A start accepted on clock edge E drives `rom_en`=1 with `rom_addr`=0 from E. The address goes up by one on each following edge until it reaches the top address 2^ADDR_W-1. On the next edge `rom_en` falls to 0.
- R3: The CRC uses polynomial 0x1021 and starts from 0xFFFF. It takes each 8-bit word MSB first and folds the whole word in one cycle. The CRC computed over the ASCII string "123456789" is 0x29B1.
- R4: The byte at address 2^ADDR_W-2 is the high byte of the stored CRC, and the byte at 2^ADDR_W-1 is the low byte. Neither byte is folded into the CRC. The final `crc_out` depends only on addresses 0 to 2^ADDR_W-3.
- R5: The ROM returns data one cycle after the address is issued. `done` rises on the edge 2^ADDR_W+1 cycles after the start edge, which is one edge after the last byte returns. `done` then stays high until the next accepted start.
- R6: `pass` is 1 only while `done` is 1 and the computed CRC equals the stored CRC exactly.
- R7: A ROM with a single-bit error, a double-bit error, an adjacent burst, or a stuck-at-0 or stuck-at-1 bit column ends with `done`=1 and `pass` equal to the exact comparison result. For single-bit, double-bit and burst errors that result is 0.
- R8: A start that arrives while a check is running is ignored. The address sequence and the time at which `done` rises are unchanged.
- R9: An accepted start clears `done` and `pass` on the same edge and resets `crc_out` to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, accepted when no check is running |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | ADDR_W | ROM read address |
| rom_data | input | 8 | ROM read data, valid one cycle after the address is issued |
| done | output | 1 | Check finished, held until the next start |
| pass | output | 1 | Computed CRC matched the stored signature |
| crc_out | output | 16 | Running or final computed CRC |

## Verification
The assertions assume that the ROM behaves as a read port with a fixed latency of one cycle. They also assume that its contents do not change while a check is running, and that `start` comes only from the driver. The bench models the ROM as a registered read of an array, so its latency is fixed by construction. It changes the array only between runs, while the checker is idle. To exercise R8 it raises `start` in the middle of a run. It also holds `start` across the edge on which `done` rises, so that requests are made both while a check is busy and right at its end.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int          BYTE_W      = 8;
    localparam int          SIG_W       = 16;
    localparam logic [15:0] DEF_POLY    = 16'h1021;
    localparam logic [15:0] DEF_SEED    = 16'hFFFF;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rcc_state_e;
endpackage

// File: rtl/rcc_crc_fold.sv
module rcc_crc_fold
    import rcc_pkg::*;
#(
    parameter logic [SIG_W-1:0] POLY = DEF_POLY
) (
    input  logic [SIG_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [SIG_W-1:0]  crc_nxt
);
    logic [SIG_W-1:0] chain [BYTE_W+1];

    assign chain[0] = crc_in;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        logic fb;
        assign fb = chain[b][SIG_W-1] ^ byte_in[BYTE_W-1-b];
        assign chain[b+1] = {chain[b][SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_nxt = chain[BYTE_W];
endmodule

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
    import rcc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rom_en,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              launch,
    output logic              rd_fold,
    output logic              rd_sig_hi,
    output logic              rd_last
);
    localparam logic [ADDR_W-1:0] LAST_A = '1;
    localparam logic [ADDR_W-1:0] SIG_A  = LAST_A - ADDR_W'(1);

    typedef struct packed {
        rcc_state_e        state;
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic              vld;
        logic [ADDR_W-1:0] vaddr;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.vld   = s_q.en;
        s_d.vaddr = s_q.addr;
        launch    = start && (s_q.state == ST_IDLE);
        if (launch) begin
            s_d.state = ST_RUN;
            s_d.en    = 1'b1;
            s_d.addr  = '0;
        end else if (s_q.state == ST_RUN) begin
            if (s_q.en) begin
                if (s_q.addr == LAST_A) s_d.en   = 1'b0;
                else                    s_d.addr = s_q.addr + ADDR_W'(1);
            end
            if (s_q.vld && (s_q.vaddr == LAST_A)) s_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rom_en    = s_q.en;
    assign rom_addr  = s_q.addr;
    assign rd_fold   = s_q.vld && (s_q.vaddr < SIG_A);
    assign rd_sig_hi = s_q.vld && (s_q.vaddr == SIG_A);
    assign rd_last   = s_q.vld && (s_q.vaddr == LAST_A);
endmodule

// File: rtl/rom_crc_checker.sv
module rom_crc_checker
    import rcc_pkg::*;
#(
    parameter int               ADDR_W = 6,
    parameter logic [SIG_W-1:0] POLY   = DEF_POLY,
    parameter logic [SIG_W-1:0] SEED   = DEF_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rom_en,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic              done,
    output logic              pass,
    output logic [15:0]       crc_out
);
    typedef struct packed {
        logic [SIG_W-1:0]  crc;
        logic [BYTE_W-1:0] sig_hi;
        logic              done;
        logic              pass;
    } dp_t;

    dp_t d_d, d_q;
    logic launch, rd_fold, rd_sig_hi, rd_last;
    logic [SIG_W-1:0] crc_fold_d;

    rcc_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .launch    (launch),
        .rd_fold   (rd_fold),
        .rd_sig_hi (rd_sig_hi),
        .rd_last   (rd_last)
    );

    rcc_crc_fold #(.POLY(POLY)) fold_i (
        .crc_in  (d_q.crc),
        .byte_in (rom_data),
        .crc_nxt (crc_fold_d)
    );

    always_comb begin
        d_d = d_q;
        if (launch) begin
            d_d.crc  = SEED;
            d_d.done = 1'b0;
            d_d.pass = 1'b0;
        end else begin
            if (rd_fold)   d_d.crc    = crc_fold_d;
            if (rd_sig_hi) d_d.sig_hi = rom_data;
            if (rd_last) begin
                d_d.done = 1'b1;
                d_d.pass = (d_q.crc == {d_q.sig_hi, rom_data});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q        <= '0;
            d_q.crc    <= SEED;
        end else begin
            d_q        <= d_d;
        end
    end

    assign done    = d_q.done;
    assign pass    = d_q.pass;
    assign crc_out = d_q.crc;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rom_en,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              done,
    input logic              pass,
    input logic [15:0]       crc_out
);
    p_pass_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    p_idle_when_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rom_en);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en && $past(rom_en)) |-> (rom_addr == $past(rom_addr) + ADDR_W'(1)));

    p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> (!done && !pass && rom_en && rom_addr == '0 && crc_out == 16'hFFFF));

    p_done_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_result_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(crc_out) && $stable(pass)));
endmodule

bind rom_crc_checker rcc_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rom_en   (rom_en),
    .rom_addr (rom_addr),
    .done     (done),
    .pass     (pass),
    .crc_out  (crc_out)
);

// File: tb/rom_crc_checker_tb_top.sv
module rom_crc_checker_tb_top;
    localparam int AW = 6;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rom_en;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          done, pass;
    logic [15:0]   crc_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] mem [D];

    always #5 clk = ~clk;

    rom_crc_checker #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rom_en(rom_en),
        .rom_addr(rom_addr), .rom_data(rom_data), .done(done),
        .pass(pass), .crc_out(crc_out)
    );

    always @(posedge clk) if (rom_en) rom_data <= mem[rom_addr];

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [15:0] ref_crc();
        logic [15:0] r = 16'hFFFF;
        for (int i = 0; i < D - 2; i++) r = crc_byte(r, mem[i]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    bit          m_busy = 1'b0;
    int          m_cnt  = 0;
    bit          m_done = 1'b0;
    bit          m_pass = 1'b0;
    logic [15:0] m_crc  = 16'hFFFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_done = 0; m_pass = 0;
        end else if (start && !m_busy) begin
            m_busy = 1; m_cnt = 0; m_done = 0; m_pass = 0;
        end else if (m_busy) begin
            m_cnt++;
            if (m_cnt == D + 1) begin
                m_busy = 0;
                m_done = 1;
                m_crc  = ref_crc();
                m_pass = (m_crc == {mem[D-2], mem[D-1]});
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_en;
            exp_en = m_busy && (m_cnt <= D - 1);
            chk(rom_en == exp_en, "R2", "rom_en", 32'(rom_en), 32'(exp_en));
            if (exp_en)
                chk(rom_addr == AW'(m_cnt), "R2", "rom_addr", 32'(rom_addr), 32'(m_cnt));
            chk(done == m_done, "R5", "done", 32'(done), 32'(m_done));
            chk(pass == m_pass, "R6", "pass", 32'(pass), 32'(m_pass));
            if (m_done)
                chk(crc_out == m_crc, "R3", "final crc", 32'(crc_out), 32'(m_crc));
            if (m_busy && m_cnt == 0)
                chk(crc_out == 16'hFFFF, "R9", "crc restart", 32'(crc_out), 32'hFFFF);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic fill_good(input int seed);
        logic [15:0] s;
        int x = seed;
        for (int i = 0; i < D - 2; i++) begin
            x = (x * 1103515245 + 12345) & 32'h7FFFFFFF;
            mem[i] = 8'(x >> 16);
        end
        s = ref_crc();
        mem[D-2] = s[15:8];
        mem[D-1] = s[7:0];
    endtask

    task automatic run(input int mid_start);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 1; k < D + 3; k++) begin
            if (k == mid_start) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    initial begin
        logic [15:0] v, saved;
        string txt;
        for (int i = 0; i < D; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0 && pass == 1'b0 && rom_en == 1'b0, "R1", "status in reset",
            {29'd0, done, pass, rom_en}, 32'd0);
        chk(crc_out == 16'hFFFF, "R1", "crc in reset", 32'(crc_out), 32'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && rom_en == 1'b0, "R1", "idle after reset", 32'(done), 32'd0);

        // R3: polynomial and seed on a known string
        txt = "123456789";
        v = 16'hFFFF;
        for (int i = 0; i < 9; i++) v = crc_byte(v, txt[i]);
        chk(v == 16'h29B1, "R3", "reference vector", 32'(v), 32'h29B1);

        // R6: intact ROM passes
        fill_good(7);
        run(0);
        chk(done && pass, "R6", "good rom pass", 32'(pass), 32'd1);
        saved = crc_out;

        // R4: corrupt only the signature; computed crc unchanged
        mem[D-2] = ~mem[D-2];
        run(0);
        chk(crc_out == saved, "R4", "signature excluded", 32'(crc_out), 32'(saved));
        chk(!pass, "R4", "bad signature fails", 32'(pass), 32'd0);

        // R7: single bit error
        fill_good(7);
        mem[5] ^= 8'h10;
        run(0);
        chk(done && !pass, "R7", "single bit", 32'(pass), 32'd0);

        // R7: double bit error
        fill_good(11);
        mem[0]  ^= 8'h01;
        mem[40] ^= 8'h80;
        run(0);
        chk(done && !pass, "R7", "double bit", 32'(pass), 32'd0);

        // R7: adjacent burst across a byte boundary
        fill_good(19);
        mem[20] ^= 8'h0F;
        mem[21] ^= 8'hF0;
        run(0);
        chk(done && !pass, "R7", "burst", 32'(pass), 32'd0);

        // R7: stuck-at-0 column, then stuck-at-1 column
        fill_good(23);
        for (int i = 0; i < D; i++) mem[i] &= 8'hF7;
        run(0);
        chk(done == 1'b1, "R7", "stuck0 done", 32'(done), 32'd1);
        fill_good(29);
        for (int i = 0; i < D; i++) mem[i] |= 8'h01;
        run(0);
        chk(done == 1'b1, "R7", "stuck1 done", 32'(done), 32'd1);

        // R8: start during run ignored (model checks timing each cycle)
        fill_good(31);
        run(10);
        chk(done && pass, "R8", "mid-run start ignored", 32'(pass), 32'd1);

        // R9: start held across the end of a run, then restart
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (D - 1) @(negedge clk);
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (D + 4) @(negedge clk);
        chk(done && pass, "R9", "restart result", 32'(pass), 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule